// File: doc/BRIEF.md
# Gated Decimal Event Counter with Holding Register

This block counts events in decimal. A chain of BCD decades, seven by default, counts rising edges of an event input, but only while a gate input is high. The decade of lowest weight advances once for each event. Each decade wraps from nine back to zero. The cycle in which it wraps, it advances the decade above it. When the top decade wraps, a sticky overflow flag is set. A synchronous clear input zeroes all decades and the overflow flag.

A holding register sits between the decades and the digit outputs. While the latch input is high, the digit outputs show the live count. While it is low, they hold the count captured at the last clock edge at which latch was high. Clear does not touch the holding register, so a finished measurement stays on the outputs while the next one is prepared.

The event input is expected to be already synchronized to `clk`. Everything runs on that one clock.

Top module: `gated_bcd_counter`

## Requirements
- R1: While `rstN` is low, and after it is released, all decades, the holding register and `overflowOut` are zero.
- R2: At the first clock edge where `eventIn` is sampled high after being sampled low, with `gateEn` high, the least significant decade advances by one. An event held high for many cycles counts once.
- R3: Rising edges of `eventIn` sampled while `gateEn` is low leave the count unchanged. This includes an edge that happened while the gate was low and is still high when the gate opens.
- R4: Each decade holds only the values 0 to 9. A decade that advances past 9 becomes 0, and at the same edge it advances the next decade.
- R5: `clearIn` high at a clock edge sets every decade to zero and clears `overflowOut`. This takes priority over a coincident event.
- R6: `overflowOut` is set at the edge where the most significant decade wraps from 9 to 0, which is the all-nines count plus one. It stays set through further counting until a clear.
- R7: While `latchIn` is high, `digitsOut` equals the live decade values in the same cycle.
- R8: While `latchIn` is low, `digitsOut` holds the decade values sampled at the last clock edge where `latchIn` was high. Counting and `clearIn` do not change it.
- R9: Decade k (k = 0 for units) appears in `digitsOut[4k+3:4k]`, with bit 4k carrying weight 2^0 and bit 4k+3 carrying weight 2^3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eventIn | input | 1 | Synchronized event signal; each rising edge is one event |
| gateEn | input | 1 | Counting permitted while high |
| clearIn | input | 1 | Synchronous clear of decades and overflow |
| latchIn | input | 1 | Holding register transparent while high |
| digitsOut | output | 4*NUM_DECADES | Held or live BCD digits, units in the low nibble |
| overflowOut | output | 1 | Sticky flag: the top decade has wrapped |

## Verification
The counter is run with single-cycle event pulses, with events held high for several cycles, and with edges that arrive while the gate is closed and stay high as it opens. Together these separate true edge counting from level counting and from gating on the wrong signal. A long run to the all-nines value and past it exercises every carry path and the overflow flag. The latch is held high while counting, which shows the outputs are live, and then dropped while counting and clearing continue, which shows the held value is frozen. The bench uses four decades so that overflow can be reached in a short run.

// File: rtl/gbc_pkg.sv
package gbc_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  typedef struct packed {
    logic countEn;
    logic clr;
    logic load;
  } ctrlStrobe_t;
endpackage

// File: rtl/gbc_ctrl.sv
module gbc_ctrl
  import gbc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        eventIn,
  input  logic        gateEn,
  input  logic        clearIn,
  input  logic        latchIn,
  output ctrlStrobe_t strobe
);
  logic prevEvent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevEvent <= 1'b0;
    else       prevEvent <= eventIn;
  end

  always_comb begin
    strobe.countEn = gateEn & eventIn & ~prevEvent;
    strobe.clr     = clearIn;
    strobe.load    = latchIn;
  end

  // R2: a held event yields a single count pulse
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countEn |=> !strobe.countEn);
  // R3: a closed gate never produces a count pulse
  assert_gate_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    !gateEn |-> !strobe.countEn);
endmodule

// File: rtl/gbc_decade.sv
module gbc_decade
  import gbc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               clr,
  input  logic               inc,
  output logic [DIGIT_W-1:0] digit,
  output logic               carry
);
  logic atMax;
  assign atMax = (digit == DIGIT_MAX);
  assign carry = inc & atMax;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      digit <= '0;
    else if (clr)   digit <= '0;
    else if (inc)   digit <= atMax ? '0 : digit + 4'd1;
  end

  // R4: value stays within BCD range
  assert_bcd_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    digit <= DIGIT_MAX);
  // R4: nine plus one wraps to zero
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !clr && digit == DIGIT_MAX) |=> digit == '0);
  // R2: a non-nine digit advances by exactly one
  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !clr && digit != DIGIT_MAX) |=> digit == $past(digit) + 4'd1);
  // R5: clear zeroes the decade
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> digit == '0);
  // R3: no increment, no clear, no change
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!inc && !clr) |=> $stable(digit));
endmodule

// File: rtl/gbc_datapath.sv
module gbc_datapath
  import gbc_pkg::*;
#(
  parameter int NUM_DECADES = 7
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobe_t                    strobe,
  output logic [NUM_DECADES*DIGIT_W-1:0] digitsOut,
  output logic                           overflowOut
);
  localparam int TOTAL_W = NUM_DECADES * DIGIT_W;

  logic [NUM_DECADES:0]  incChain;
  logic [TOTAL_W-1:0]    liveDigits;
  logic [TOTAL_W-1:0]    heldDigits;
  logic                  ovfQ;

  assign incChain[0] = strobe.countEn;

  for (genvar k = 0; k < NUM_DECADES; k++) begin : gDecade
    gbc_decade uDecade (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (strobe.clr),
      .inc   (incChain[k]),
      .digit (liveDigits[k*DIGIT_W +: DIGIT_W]),
      .carry (incChain[k+1])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ovfQ <= 1'b0;
    else if (strobe.clr)       ovfQ <= 1'b0;
    else if (incChain[NUM_DECADES]) ovfQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            heldDigits <= '0;
    else if (strobe.load) heldDigits <= liveDigits;
  end

  assign digitsOut   = strobe.load ? liveDigits : heldDigits;
  assign overflowOut = ovfQ;

  // R6: top carry sets the flag
  assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (incChain[NUM_DECADES] && !strobe.clr) |=> overflowOut);
  // R6: flag is sticky until clear
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (overflowOut && !strobe.clr) |=> overflowOut);
  // R5: clear drops the flag
  assert_ovf_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> !overflowOut);
  // R8: holding register frozen while latch low
  assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(heldDigits));
endmodule

// File: rtl/gated_bcd_counter.sv
module gated_bcd_counter
  import gbc_pkg::*;
#(
  parameter int NUM_DECADES = 7
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           eventIn,
  input  logic                           gateEn,
  input  logic                           clearIn,
  input  logic                           latchIn,
  output logic [NUM_DECADES*DIGIT_W-1:0] digitsOut,
  output logic                           overflowOut
);
  ctrlStrobe_t strobe;

  gbc_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .eventIn (eventIn),
    .gateEn  (gateEn),
    .clearIn (clearIn),
    .latchIn (latchIn),
    .strobe  (strobe)
  );

  gbc_datapath #(.NUM_DECADES(NUM_DECADES)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .digitsOut   (digitsOut),
    .overflowOut (overflowOut)
  );
endmodule

// File: tb/sim_gated_bcd_counter.sv
`timescale 1ns/1ps
module sim_gated_bcd_counter;
  localparam int ND   = 4;
  localparam int W    = ND * 4;
  localparam int MAXC = 10 ** ND;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eventIn = 1'b0, gateEn = 1'b0, clearIn = 1'b0, latchIn = 1'b0;
  logic [W-1:0] digitsOut;
  logic overflowOut;

  int testsRun = 0;
  int testsFailed = 0;
  string curReq = "R1";

  int mCount = 0, mStored = 0;
  bit mOvf = 0, mPrev = 0;

  always #2.5 clk = ~clk;

  gated_bcd_counter #(.NUM_DECADES(ND)) u0 (
    .clk(clk), .rstN(rstN), .eventIn(eventIn), .gateEn(gateEn),
    .clearIn(clearIn), .latchIn(latchIn),
    .digitsOut(digitsOut), .overflowOut(overflowOut)
  );

  function automatic logic [W-1:0] toBcd(int v);
    logic [W-1:0] r;
    int t = v;
    for (int k = 0; k < ND; k++) begin
      r[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mStored = 0; mOvf = 0; mPrev = 0;
    end else begin
      if (latchIn) mStored = mCount;
      if (clearIn) begin
        mCount = 0; mOvf = 0;
      end else if (gateEn && eventIn && !mPrev) begin
        mCount = mCount + 1;
        if (mCount == MAXC) begin mCount = 0; mOvf = 1; end
      end
      mPrev = eventIn;
    end
  end

  task automatic check(string req, logic [W:0] act, logic [W:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(posedge clk); #1;
    if (rstN) check(curReq, {overflowOut, digitsOut},
                    {mOvf, toBcd(latchIn ? mCount : mStored)});
  end

  task automatic pulseEvent();
    @(negedge clk) eventIn = 1'b1;
    @(negedge clk) eventIn = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    testsFailed++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    idle(4);
    @(posedge clk); #1;
    check("R1", {overflowOut, digitsOut}, '0);
    @(negedge clk) rstN = 1'b1;
    idle(2);
    check("R1", {overflowOut, digitsOut}, '0);

    // R2/R4/R7: counting with latch open, through a decade carry
    curReq = "R2_R4_R7";
    latchIn = 1'b1; gateEn = 1'b1;
    for (int i = 0; i < 23; i++) pulseEvent();
    idle(1);
    check("R4", {overflowOut, digitsOut}, {1'b0, 16'h0023});

    // R2: held event counts once
    curReq = "R2";
    @(negedge clk) eventIn = 1'b1;
    idle(6);
    @(negedge clk) eventIn = 1'b0;
    idle(1);
    check("R2", {overflowOut, digitsOut}, {1'b0, 16'h0024});

    // R3: closed gate, then edge seen closed and gate opened while high
    curReq = "R3";
    gateEn = 1'b0;
    for (int i = 0; i < 5; i++) pulseEvent();
    @(negedge clk) eventIn = 1'b1;
    @(negedge clk) gateEn = 1'b1;
    idle(3);
    @(negedge clk) eventIn = 1'b0;
    idle(1);
    check("R3", {overflowOut, digitsOut}, {1'b0, 16'h0024});

    // R9: digit placement
    curReq = "R9";
    for (int i = 0; i < 1210; i++) pulseEvent();
    idle(1);
    check("R9", {overflowOut, digitsOut}, {1'b0, 16'h1234});

    // R8: latch closed while counting and clearing
    curReq = "R8";
    @(negedge clk) latchIn = 1'b0;
    for (int i = 0; i < 7; i++) pulseEvent();
    check("R8", {overflowOut, digitsOut}, {1'b0, 16'h1234});
    @(negedge clk) clearIn = 1'b1;
    @(negedge clk) clearIn = 1'b0;
    idle(1);
    check("R8", {overflowOut, digitsOut}, {1'b0, 16'h1234});
    @(negedge clk) latchIn = 1'b1;
    idle(1);
    check("R5", {overflowOut, digitsOut}, '0);

    // R5: clear coincident with an event
    curReq = "R5";
    for (int i = 0; i < 4; i++) pulseEvent();
    @(negedge clk) begin eventIn = 1'b1; clearIn = 1'b1; end
    @(negedge clk) begin eventIn = 1'b0; clearIn = 1'b0; end
    idle(1);
    check("R5", {overflowOut, digitsOut}, '0);

    // R6: all nines, then overflow, stickiness, clear
    curReq = "R6";
    for (int i = 0; i < MAXC - 1; i++) pulseEvent();
    idle(1);
    check("R6", {overflowOut, digitsOut}, {1'b0, 16'h9999});
    pulseEvent();
    idle(1);
    check("R6", {overflowOut, digitsOut}, {1'b1, 16'h0000});
    for (int i = 0; i < 3; i++) pulseEvent();
    check("R6", {overflowOut, digitsOut}, {1'b1, 16'h0003});
    @(negedge clk) clearIn = 1'b1;
    @(negedge clk) clearIn = 1'b0;
    idle(1);
    check("R5", {overflowOut, digitsOut}, '0);

    idle(3);
    finishRun();
  end
endmodule